// File: doc/BRIEF.md
# Calendar Alarm Comparator

This unit watches a running BCD calendar and raises an alarm when the current time matches a programmed 32-bit alarm word. The calendar keeper pulses a once-per-second update strobe, and the comparison is evaluated only on that strobe. Each time field in the alarm word (seconds, minutes, hours with a PM flag, and day) has its own don't-care bit. The day field matches either a day of the month or a weekday, chosen by a select bit.

A match sets a sticky event flag. Software clears the flag by writing zero to it. When the interrupt enable is set, the flag drives the interrupt output. The alarm word is protected by a write-allowed indication. That indication drops as soon as the alarm is enabled and returns a fixed number of clock cycles after the alarm is disabled. Writes to the alarm word while it is low are discarded.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0000_0001 (write-allowed set, event flag clear), the alarm word reads 0, and `irq` is low.
- R2: The alarm word layout is seconds BCD in bits 6:0, minutes BCD in bits 14:8, hours BCD in bits 21:16, and PM in bit 22. With all masks clear, a match needs each of these fields equal to `cal_sec`, `cal_min`, `cal_hour` and `cal_pm`.
- R3: Bits 7, 15, 23 and 31 are the don't-care bits for seconds, minutes, hours (including PM) and day. A set bit removes that field from the comparison, so with bit 31 set the alarm fires on every day at the matching time.
- R4: With bit 30 clear, bits 29:24 are compared against the BCD day of month `cal_mday`. With bit 30 set, bits 27:24 are compared against the weekday `cal_wday` (1 to 7), and bits 29:28 are ignored.
- R5: The PM bit takes part in the hour comparison. In 24-hour operation `cal_pm` is 0, so an alarm word with bit 22 set does not match.
- R6: The comparison takes effect only in a cycle where `tick_1hz` is high and the alarm enable is set. Without a strobe, or with the alarm disabled, the event flag is not set.
- R7: The event flag (status bit 8) stays set until a status write with bit 8 equal to 0. A status write with bit 8 equal to 1 has no effect. A match and a clearing write in the same cycle leave the flag set.
- R8: `irq` is high exactly when the event flag and the interrupt enable (control bit 12) are both set.
- R9: The write-allowed bit (status bit 0) falls on the clock edge that sets the alarm enable (control bit 8). It rises on the second clock edge after the edge that clears the enable.
- R10: A write to the alarm word while write-allowed is low leaves the stored alarm word unchanged.
- R11: The register select `reg_addr` maps 0 to control, 1 to status and 2 to the alarm word. `reg_rdata` shows the selected register in the same cycle, and unused bits read 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | Calendar update strobe, one cycle per second |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_pm | input | 1 | Current PM indicator |
| cal_mday | input | 6 | Current day of month, BCD |
| cal_wday | input | 3 | Current weekday, 1 to 7 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the unit with the default write-allowed delay of two cycles. Sampling the status register on three consecutive cycles after the enable is cleared therefore shows both low cycles and the rising edge, which pins the delay exactly. The fixed field widths mean every mask, the select bit and the PM bit can each be reached by a single vector. Directed steps then cover the case where a set and a clear land in the same cycle, and the case where a protected write is dropped.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int REG_W       = 32;
    localparam int SEL_W       = 2;
    localparam int TFIELD_W    = 7;
    localparam int NUM_TFIELDS = 3;
    localparam int TFIELD_PITCH = 8;

    // register select codes
    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_ALARM = 2'd2
    } reg_sel_e;

    // control and status bit positions
    localparam int CTRL_EN_BIT   = 8;
    localparam int CTRL_IE_BIT   = 12;
    localparam int STAT_WOK_BIT  = 0;
    localparam int STAT_FLAG_BIT = 8;

    // alarm word day field
    localparam int DAY_LSB     = 24;
    localparam int MDAY_W      = 6;
    localparam int WDAY_W      = 3;
    localparam int DAY_SEL_BIT = 30;
    localparam int DAY_MSK_BIT = 31;

endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field #(
    parameter int W = 7
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] have,
    input  logic         dont_care,
    output logic         hit
);
    always_comb hit = dont_care || (want == have);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic [REG_W-1:0]  alarm_word,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic              cal_pm,
    input  logic [MDAY_W-1:0] cal_mday,
    input  logic [WDAY_W-1:0] cal_wday,
    output logic              all_hit
);
    logic [TFIELD_W-1:0] have [NUM_TFIELDS];
    logic [NUM_TFIELDS-1:0] fld_hit;
    logic day_hit;

    always_comb begin
        have[0] = cal_sec;
        have[1] = cal_min;
        have[2] = {cal_pm, cal_hour};
    end

    for (genvar i = 0; i < NUM_TFIELDS; i++) begin : g_tfield
        cal_alarm_field #(.W(TFIELD_W)) u_field (
            .want      (alarm_word[i*TFIELD_PITCH +: TFIELD_W]),
            .have      (have[i]),
            .dont_care (alarm_word[i*TFIELD_PITCH + TFIELD_W]),
            .hit       (fld_hit[i])
        );
    end

    always_comb begin
        if (alarm_word[DAY_SEL_BIT])
            day_hit = alarm_word[DAY_LSB +: WDAY_W+1] == {1'b0, cal_wday};
        else
            day_hit = alarm_word[DAY_LSB +: MDAY_W] == cal_mday;
        all_hit = (&fld_hit) && (alarm_word[DAY_MSK_BIT] || day_hit);
    end
endmodule

// File: rtl/cal_alarm_wrgate.sv
module cal_alarm_wrgate #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic en_next,
    output logic wr_ok
);
    localparam int CNT_W = $clog2(DELAY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (en_next || en_q) begin
            g_d.cnt = '0;
            g_d.ok  = 1'b0;
        end else if (!g_q.ok) begin
            if (g_q.cnt == CNT_W'(DELAY - 1))
                g_d.ok = 1'b1;
            else
                g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.cnt <= '0;
            g_q.ok  <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign wr_ok = g_q.ok;
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int WOK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic              cal_pm,
    input  logic [5:0]        cal_mday,
    input  logic [2:0]        cal_wday,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             ie;
        logic [REG_W-1:0] alarm;
        logic             flag;
    } state_t;

    state_t st_d, st_q;

    logic hit;
    logic wr_ok;
    logic en_q, flag_q, ie_q;
    logic [REG_W-1:0] alarm_q;

    assign en_q    = st_q.en;
    assign ie_q    = st_q.ie;
    assign flag_q  = st_q.flag;
    assign alarm_q = st_q.alarm;

    cal_alarm_match u_match (
        .alarm_word (st_q.alarm),
        .cal_sec    (cal_sec),
        .cal_min    (cal_min),
        .cal_hour   (cal_hour),
        .cal_pm     (cal_pm),
        .cal_mday   (cal_mday),
        .cal_wday   (cal_wday),
        .all_hit    (hit)
    );

    cal_alarm_wrgate #(.DELAY(WOK_DELAY)) u_wrgate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (st_q.en),
        .en_next (st_d.en),
        .wr_ok   (wr_ok)
    );

    always_comb begin
        logic wr_ctrl, wr_stat, wr_alarm, set_ev, clr_ev;
        wr_ctrl  = reg_wr && (reg_addr == SEL_CTRL);
        wr_stat  = reg_wr && (reg_addr == SEL_STAT);
        wr_alarm = reg_wr && (reg_addr == SEL_ALARM);
        set_ev   = tick_1hz && st_q.en && hit;
        clr_ev   = wr_stat && !reg_wdata[STAT_FLAG_BIT];

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en = reg_wdata[CTRL_EN_BIT];
            st_d.ie = reg_wdata[CTRL_IE_BIT];
        end
        if (wr_alarm && wr_ok)
            st_d.alarm = reg_wdata;
        if (set_ev)
            st_d.flag = 1'b1;
        else if (clr_ev)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: begin
                reg_rdata[CTRL_EN_BIT] = st_q.en;
                reg_rdata[CTRL_IE_BIT] = st_q.ie;
            end
            SEL_STAT: begin
                reg_rdata[STAT_WOK_BIT]  = wr_ok;
                reg_rdata[STAT_FLAG_BIT] = st_q.flag;
            end
            SEL_ALARM: reg_rdata = st_q.alarm;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = st_q.flag && st_q.ie;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq,
    input logic        en_q,
    input logic        flag_q,
    input logic        hit,
    input logic        wr_ok,
    input logic [31:0] alarm_q
);
    // R6
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && en_q && hit) |=> flag_q);

    // R6
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick_1hz));

    // R7
    flag_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(reg_wr && reg_addr == 2'd1 && !reg_wdata[8]));

    // R8
    irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    // R9
    wok_drops_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> !wr_ok);

    // R10
    alarm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(alarm_q));
endmodule

bind cal_alarm_unit cal_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .hit       (hit),
    .wr_ok     (wr_ok),
    .alarm_q   (alarm_q)
);

// File: tb/cal_alarm_unit_bench.sv
module cal_alarm_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [31:0] aw;
        logic [22:0] tm;
        logic [23:0] dt;
        logic        hit;
    } vec_t;

    // tm: sec 6:0, min 14:8, hour 21:16, pm 22; dt: mday 5:0, wday 15:13
    localparam vec_t VECS [NVEC] = '{
        '{32'h15123456, 23'h123456, 24'h006315, 1'b1}, // R2 exact
        '{32'h15123456, 23'h123457, 24'h006315, 1'b0}, // R2 sec differs
        '{32'h151234D6, 23'h123400, 24'h006315, 1'b1}, // R3 sec masked
        '{32'h1512B456, 23'h125956, 24'h006315, 1'b1}, // R3 min masked
        '{32'h15923456, 23'h073456, 24'h006315, 1'b1}, // R3 hour masked
        '{32'h95123456, 23'h123456, 24'h006328, 1'b1}, // R3 day masked
        '{32'h15123456, 23'h123456, 24'h006316, 1'b0}, // R4 mday differs
        '{32'h43123456, 23'h123456, 24'h006301, 1'b1}, // R4 weekday hit
        '{32'h43123456, 23'h123456, 24'h00A315, 1'b0}, // R4 weekday miss
        '{32'h73123456, 23'h123456, 24'h006301, 1'b1}, // R4 bits 29:28 ignored
        '{32'h15523456, 23'h123456, 24'h006315, 1'b0}, // R5 pm set, 24h time
        '{32'h15523456, 23'h523456, 24'h006315, 1'b1}, // R5 pm both
        '{32'h80808080, 23'h010203, 24'h002009, 1'b1}, // R3 all masked
        '{32'h15235959, 23'h225959, 24'h006315, 1'b0}  // R2 hour differs
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [6:0]  cal_sec = '0;
    logic [6:0]  cal_min = '0;
    logic [5:0]  cal_hour = '0;
    logic        cal_pm = 1'b0;
    logic [5:0]  cal_mday = '0;
    logic [2:0]  cal_wday = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_alarm_unit u_cal_alarm_unit (
        .clk, .rst_n, .tick_1hz, .cal_sec, .cal_min, .cal_hour, .cal_pm,
        .cal_mday, .cal_wday, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic drive_cal(input logic [22:0] tm, input logic [23:0] dt);
        cal_sec = tm[6:0]; cal_min = tm[14:8]; cal_hour = tm[21:16]; cal_pm = tm[22];
        cal_mday = dt[5:0]; cal_wday = dt[15:13];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 32'h0);
        rd(2'd1, v); check("R1 status", v, 32'h1);
        rd(2'd2, v); check("R1 alarm", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 32'h0);
            repeat (2) @(negedge clk);
            wr(2'd2, VECS[i].aw);
            wr(2'd1, 32'h0);
            drive_cal(VECS[i].tm, VECS[i].dt);
            wr(2'd0, 32'h1100);
            pulse_tick();
            rd(2'd1, v);
            check($sformatf("R2-R5 vec%0d flag", i), {31'b0, v[8]}, {31'b0, VECS[i].hit});
            check($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].hit});
        end

        // R6 tick with alarm disabled
        wr(2'd0, 32'h0);
        repeat (2) @(negedge clk);
        wr(2'd2, 32'h15123456);
        wr(2'd1, 32'h0);
        drive_cal(23'h123456, 24'h006315);
        pulse_tick();
        rd(2'd1, v); check("R6 disabled tick", {31'b0, v[8]}, 32'h0);

        // R9 falls with enable, R11 ctrl readback
        wr(2'd0, 32'h1100);
        rd(2'd1, v); check("R9 wok low when enabled", {31'b0, v[0]}, 32'h0);
        rd(2'd0, v); check("R11 ctrl readback", v, 32'h1100);

        // R6 no tick, no flag
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R6 no tick", {31'b0, v[8]}, 32'h0);

        // R10 protected write
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R10 alarm locked", v, 32'h15123456);

        // R6 tick hits
        pulse_tick();
        rd(2'd1, v); check("R6 tick sets flag", {31'b0, v[8]}, 32'h1);
        check("R8 irq on", {31'b0, irq}, 32'h1);

        // R7 write one ignored
        wr(2'd1, 32'h101);
        rd(2'd1, v); check("R7 write one", {31'b0, v[8]}, 32'h1);

        // R8 interrupt enable off
        wr(2'd0, 32'h0100);
        check("R8 irq masked", {31'b0, irq}, 32'h0);

        // R7 clear
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R7 clear", {31'b0, v[8]}, 32'h0);

        // R7 set wins over clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0; tick_1hz = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_1hz = 1'b0;
        rd(2'd1, v); check("R7 set beats clear", {31'b0, v[8]}, 32'h1);

        // R9 rise timing after disable
        wr(2'd0, 32'h0);
        rd(2'd1, v); check("R9 wok edge0", {31'b0, v[0]}, 32'h0);
        @(negedge clk);
        rd(2'd1, v); check("R9 wok edge1", {31'b0, v[0]}, 32'h0);
        @(negedge clk);
        rd(2'd1, v); check("R9 wok edge2", {31'b0, v[0]}, 32'h1);

        // R10 write allowed now
        wr(2'd2, 32'h00000042);
        rd(2'd2, v); check("R10 alarm writable", v, 32'h00000042);

        finish_run();
    end
endmodule